// File: doc/BRIEF.md
# Digital FIFO Jitter Attenuator

This block smooths a two-bit dual-rail symbol stream that arrives with irregular spacing. Each symbol is written into a small elastic store when `in_valid` pulses. Symbols leave the store on read strobes made by a phase-accumulator oscillator. That oscillator runs only on the fixed master clock `clk`, so no other fast clock is needed. The oscillator increment starts at a nominal value and is trimmed in proportion to how far the fill level sits from half depth. This closes a slow frequency-tracking loop, so the outgoing symbol spacing follows the average input rate rather than its short-term wander.

Near either end of the store, the loop changes from a small correction gain to a large one. Two entries of margin define each end, and in that state the read rate follows the input closely. The small gain returns once the fill has left both margins. If the store still overflows or underflows, the block flags the event and re-centres itself. The depth is 32 or 64 entries, picked by `depth_sel`. A bypass control routes the input straight to the output through one register.

Top module: `jitter_atten`

## Requirements
- R1: Symbols are 2 bits wide. `depth_sel`=0 gives a depth D of 32 and `depth_sel`=1 gives 64. Symbols leave on `out_data` with `out_valid` high, in the order they were written, none lost or repeated while no overflow or underflow occurs.
- R2: While `rst` is high, every output is 0. After reset, and after any re-centring, the store holds D/2 placeholder entries, and the first D/2 reads present `out_data`=00. Throughput delay is therefore D/2 symbols.
- R3: Read strobes come only from an accumulator clocked by `clk`, so `out_valid` is never high on two consecutive cycles outside bypass. `out_clk` is the accumulator's top bit.
- R4: `wide_bw` is 1 on the cycle after the fill level was at most 2 or at least D-2, and 0 after it was anywhere between.
- R5: When writes arrive at the nominal average rate, with or without short-term spacing jitter, the fill stays off both margins. Neither `wide_bw`, `ovf_evt` nor `unf_evt` rises.
- R6: A write into a full store with no read that cycle is dropped. `ovf_evt` pulses for one cycle and the store re-centres to D/2 entries, as in R2.
- R7: A read strobe on an empty store produces no output. `unf_evt` pulses for one cycle and the store re-centres to D/2 entries, as in R2.
- R8: Changing `depth_sel` without reset re-centres the store at the new depth, as in R2.
- R9: With `bypass`=1, `out_valid` and `out_data` equal `in_valid` and `in_data` one cycle earlier. The store is held re-centred and both event outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | 1 routes the input straight to the output |
| depth_sel | input | 1 | Store depth: 0 for 32, 1 for 64 |
| in_valid | input | 1 | Write strobe, one per incoming symbol |
| in_data | input | 2 | Incoming dual-rail symbol |
| out_valid | output | 1 | Outgoing symbol strobe |
| out_data | output | 2 | Outgoing symbol |
| out_clk | output | 1 | Synthesized read clock (accumulator top bit) |
| wide_bw | output | 1 | Loop is in the large-gain state |
| ovf_evt | output | 1 | One-cycle pulse on overflow |
| unf_evt | output | 1 | One-cycle pulse on underflow |

## Verification
The smoothing path is driven with four stimuli. Evenly spaced writes at the nominal rate show the base delay and order. Writes whose spacing wanders around the same mean show that jitter does not push the fill into the margins. A sudden stop in writes must raise the large-gain state before the underflow event. Back-to-back writes must do the same before the overflow event. A depth change in mid-stream shows the larger placeholder count. Single symbols in bypass tell the one-register path apart from the store path.

// File: rtl/jatt_pkg.sv
`timescale 1ns/1ps
package jatt_pkg;
  typedef logic [1:0] sym_t;

  // true when a fill level sits inside the guard margin at either end
  function automatic logic in_guard(input int unsigned lvl, input int unsigned dep,
                                    input int unsigned grd);
    return (lvl <= grd) || (lvl + grd >= dep);
  endfunction
endpackage

// File: rtl/jatt_fifo.sv
`timescale 1ns/1ps
module jatt_fifo #(
  parameter int AW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init,
  input  logic [AW:0]    depth,
  input  logic           wr,
  input  jatt_pkg::sym_t wdata,
  input  logic           rd,
  output logic           rd_valid,
  output jatt_pkg::sym_t rd_data,
  output logic           rd_stale,
  output logic           ovf,
  output logic           unf,
  output logic [AW:0]    fill
);
  import jatt_pkg::*;
  localparam int N = 1 << AW;

  sym_t          mem [N];
  logic [AW-1:0] wptr, rptr, mask, wbase;
  logic [AW:0]   half, stale_cnt;
  logic          full_hit, empty_hit, slip, we, re;

  assign mask      = AW'(depth - (AW+1)'(1));
  assign half      = depth >> 1;
  assign full_hit  = wr && !rd && (fill == depth);
  assign empty_hit = rd && (fill == '0);
  assign slip      = full_hit || empty_hit;
  assign we        = wr && !init && !slip;
  assign re        = rd && !init && !slip;
  assign wbase     = rst ? '0 : (wptr & mask);

  // storage: plain write port and registered read port
  always_ff @(posedge clk) begin
    if (we) mem[wptr] <= wdata;
    if (re) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (init) begin
      wptr      <= wbase;
      rptr      <= (wbase - half[AW-1:0]) & mask;
      fill      <= half;
      stale_cnt <= half;
      rd_valid  <= 1'b0;
      rd_stale  <= 1'b0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else if (slip) begin
      rptr      <= (wptr - half[AW-1:0]) & mask;
      fill      <= half;
      stale_cnt <= half;
      rd_valid  <= 1'b0;
      ovf       <= full_hit;
      unf       <= empty_hit;
    end else begin
      ovf      <= 1'b0;
      unf      <= 1'b0;
      rd_valid <= re;
      if (we) wptr <= (wptr + 1'b1) & mask;
      if (re) begin
        rptr     <= (rptr + 1'b1) & mask;
        rd_stale <= (stale_cnt != '0);
        if (stale_cnt != '0) stale_cnt <= stale_cnt - 1'b1;
      end
      fill <= fill + (AW+1)'(we) - (AW+1)'(re);
    end
  end
endmodule

// File: rtl/jatt_loop.sv
`timescale 1ns/1ps
module jatt_loop #(
  parameter int              AW        = 6,
  parameter int              ACC_W     = 24,
  parameter logic [ACC_W-1:0] NOM_INC  = 24'h200000,
  parameter int              GUARD     = 2,
  parameter int              NARROW_SH = 6,
  parameter int              WIDE_SH   = 1,
  parameter int              ERR_SC    = 16
) (
  input  logic             clk,
  input  logic             init,
  input  logic [AW:0]      fill,
  input  logic [AW:0]      depth,
  output logic             wide,
  output logic [ACC_W-1:0] inc
);
  import jatt_pkg::*;
  localparam int EW = ACC_W + 2;
  localparam logic signed [EW-1:0] MAX_S = EW'(longint'(1) << (ACC_W - 1));
  localparam logic signed [EW-1:0] MIN_S = EW'(1);

  logic [AW:0]             half;
  logic signed [AW+1:0]    err;
  logic signed [EW-1:0]    scaled, corr, sum;
  logic                    win;
  logic [ACC_W-1:0]        inc_n;

  assign half   = depth >> 1;
  assign err    = $signed({1'b0, fill}) - $signed({1'b0, half});
  assign scaled = EW'(err) <<< ERR_SC;
  assign win    = in_guard(32'(fill), 32'(depth), 32'(GUARD));

  // gain picked by the guard window; result clamped to a legal rate
  always_comb begin
    corr = win ? (scaled >>> WIDE_SH) : (scaled >>> NARROW_SH);
    sum  = $signed({2'b00, NOM_INC}) + corr;
    if (sum < MIN_S)      inc_n = ACC_W'(MIN_S);
    else if (sum > MAX_S) inc_n = ACC_W'(MAX_S);
    else                  inc_n = ACC_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (init) begin
      inc  <= NOM_INC;
      wide <= 1'b0;
    end else begin
      inc  <= inc_n;
      wide <= win;
    end
  end
endmodule

// File: rtl/jatt_nco.sv
`timescale 1ns/1ps
module jatt_nco #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             init,
  input  logic [ACC_W-1:0] inc,
  output logic             stb,
  output logic             msb
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   nxt;

  assign nxt = {1'b0, acc} + {1'b0, inc};
  assign msb = acc[ACC_W-1];

  always_ff @(posedge clk) begin
    if (init) begin
      acc <= '0;
      stb <= 1'b0;
    end else begin
      acc <= nxt[ACC_W-1:0];
      stb <= nxt[ACC_W];
    end
  end
endmodule

// File: rtl/jitter_atten.sv
`timescale 1ns/1ps
module jitter_atten #(
  parameter int               AW        = 6,
  parameter int               ACC_W     = 24,
  parameter logic [ACC_W-1:0] NOM_INC   = 24'h200000,
  parameter int               GUARD     = 2,
  parameter int               NARROW_SH = 6,
  parameter int               WIDE_SH   = 1,
  parameter int               ERR_SC    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bypass,
  input  logic       depth_sel,
  input  logic       in_valid,
  input  logic [1:0] in_data,
  output logic       out_valid,
  output logic [1:0] out_data,
  output logic       out_clk,
  output logic       wide_bw,
  output logic       ovf_evt,
  output logic       unf_evt
);
  import jatt_pkg::*;
  localparam int DEEP    = 1 << AW;
  localparam int SHALLOW = 1 << (AW - 1);

  logic             dsel_q, init_w, stb_w, msb_w, rd_valid_w, rd_stale_w;
  logic [AW:0]      depth_w, fill_w;
  logic [ACC_W-1:0] inc_w;
  sym_t             rd_data_w;

  assign depth_w = depth_sel ? (AW+1)'(DEEP) : (AW+1)'(SHALLOW);
  assign init_w  = rst || bypass || (depth_sel != dsel_q);

  always_ff @(posedge clk) dsel_q <= depth_sel;

  jatt_fifo #(.AW(AW)) u_fifo (
    .clk(clk), .rst(rst), .init(init_w), .depth(depth_w),
    .wr(in_valid), .wdata(in_data), .rd(stb_w),
    .rd_valid(rd_valid_w), .rd_data(rd_data_w), .rd_stale(rd_stale_w),
    .ovf(ovf_evt), .unf(unf_evt), .fill(fill_w)
  );

  jatt_loop #(
    .AW(AW), .ACC_W(ACC_W), .NOM_INC(NOM_INC), .GUARD(GUARD),
    .NARROW_SH(NARROW_SH), .WIDE_SH(WIDE_SH), .ERR_SC(ERR_SC)
  ) u_loop (
    .clk(clk), .init(init_w), .fill(fill_w), .depth(depth_w),
    .wide(wide_bw), .inc(inc_w)
  );

  jatt_nco #(.ACC_W(ACC_W)) u_nco (
    .clk(clk), .init(init_w), .inc(inc_w), .stb(stb_w), .msb(msb_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_clk   <= 1'b0;
    end else if (bypass) begin
      out_valid <= in_valid;
      out_data  <= in_data;
      out_clk   <= 1'b0;
    end else begin
      out_valid <= rd_valid_w;
      out_clk   <= msb_w;
      if (rd_valid_w) out_data <= rd_stale_w ? 2'b00 : rd_data_w;
    end
  end
endmodule

// File: rtl/jatt_checker.sv
`timescale 1ns/1ps
module jatt_checker #(
  parameter int               AW        = 6,
  parameter int               ACC_W     = 24,
  parameter logic [ACC_W-1:0] NOM_INC   = 24'h200000,
  parameter int               GUARD     = 2,
  parameter int               NARROW_SH = 6,
  parameter int               ERR_SC    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bypass,
  input logic             depth_sel,
  input logic             init,
  input logic             in_valid,
  input logic [1:0]       in_data,
  input logic             out_valid,
  input logic [1:0]       out_data,
  input logic             wide_bw,
  input logic             ovf_evt,
  input logic             unf_evt,
  input logic [AW:0]      fill,
  input logic [AW:0]      depth,
  input logic [ACC_W-1:0] inc
);
  import jatt_pkg::*;
  localparam longint BOUND = (longint'(1 << (AW - 1)) << ERR_SC) >> NARROW_SH;

  logic guard_now;
  assign guard_now = in_guard(32'(fill), 32'(depth), 32'(GUARD));

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= depth) else $error("fill above depth"); // R1

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !bypass && !$past(bypass)) |=> (!out_valid || bypass))
    else $error("back-to-back reads"); // R3

  AST_WIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(init)) |-> (wide_bw == $past(guard_now)))
    else $error("wide state mismatch"); // R4

  AST_NARROW_INC: assert property (@(posedge clk) disable iff (rst)
    !wide_bw |-> ((longint'(inc) <= longint'(NOM_INC) + BOUND) &&
                  (longint'(inc) + BOUND >= longint'(NOM_INC))))
    else $error("narrow increment out of range"); // R5

  AST_OVF_RECENTER: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |-> (fill == (depth >> 1) && !unf_evt))
    else $error("overflow not re-centred"); // R6

  AST_UNF_RECENTER: assert property (@(posedge clk) disable iff (rst)
    unf_evt |-> (fill == (depth >> 1)))
    else $error("underflow not re-centred"); // R7

  AST_DEPTH_RECENTER: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !bypass && depth_sel != $past(depth_sel)) |=> (fill == (depth >> 1)))
    else $error("depth change not re-centred"); // R8

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    ($past(bypass) && !$past(rst)) |->
      (out_valid == $past(in_valid) && out_data == $past(in_data) && !ovf_evt && !unf_evt))
    else $error("bypass path mismatch"); // R9
endmodule

bind jitter_atten jatt_checker #(
  .AW(AW), .ACC_W(ACC_W), .NOM_INC(NOM_INC), .GUARD(GUARD),
  .NARROW_SH(NARROW_SH), .ERR_SC(ERR_SC)
) u_chk (
  .clk(clk), .rst(rst), .bypass(bypass), .depth_sel(depth_sel), .init(init_w),
  .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
  .wide_bw(wide_bw), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
  .fill(fill_w), .depth(depth_w), .inc(inc_w)
);

// File: tb/jitter_atten_bench.sv
`timescale 1ns/1ps
module jitter_atten_bench;
  logic       clk = 1'b0, rst = 1'b1, bypass = 1'b0, depth_sel = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_data = 2'b00;
  logic       out_valid, out_clk, wide_bw, ovf_evt, unf_evt;
  logic [1:0] out_data;

  jitter_atten u_jitter_atten (
    .clk(clk), .rst(rst), .bypass(bypass), .depth_sel(depth_sel),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .out_clk(out_clk), .wide_bw(wide_bw),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  always #2.5 clk = ~clk;

  int         nvec = 0, nerr = 0, dcur = 32, sym_k = 0;
  int         ovf_cnt = 0, unf_cnt = 0, wide_cnt = 0, wide_at_evt = 0;
  int         clk_hi = 0, samples = 0;
  bit         mon_on = 0, prev_ov = 0, done = 0;
  logic [1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_zeros(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(2'b00);
  endtask

  // monitor: pop expected symbols as the design emits them
  initial forever begin
    @(posedge clk); #1;
    if (mon_on) begin
      if (out_valid) begin
        chk(!prev_ov, "R3 consecutive out_valid", 1, 0);
        if (exp_q.size() == 0) chk(0, "R1 unexpected output", int'(out_data), -1);
        else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, (e == 2'b00) ? "R2 placeholder symbol" : "R1 symbol order",
              int'(out_data), int'(e));
        end
      end
      if (ovf_evt || unf_evt) begin
        if (ovf_evt) ovf_cnt++;
        if (unf_evt) unf_cnt++;
        wide_at_evt = wide_cnt;
        exp_q.delete();
        push_zeros(dcur / 2);
      end
      if (wide_bw) wide_cnt++;
      if (out_clk) clk_hi++;
      samples++;
    end
    prev_ov = out_valid;
  end

  task automatic wr(input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 2'((sym_k % 3) + 1);
    sym_k++;
    exp_q.push_back(in_data);
    for (int i = 1; i < gap; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic wait_read_slot();
    do @(negedge clk); while (!out_valid);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 0 && wide_bw == 0, "R2 reset outputs", int'({out_valid, wide_bw}), 0);
    chk(ovf_evt == 0 && unf_evt == 0, "R2 reset events", int'({ovf_evt, unf_evt}), 0);
    push_zeros(16);
    mon_on = 1;
    rst = 1'b0;

    // evenly spaced writes at the nominal rate
    wide_cnt = 0; clk_hi = 0; samples = 0;
    for (int i = 0; i < 200; i++) wr(8);
    chk(wide_cnt == 0, "R5 wide during steady", wide_cnt, 0);
    chk(ovf_cnt + unf_cnt == 0, "R5 events during steady", ovf_cnt + unf_cnt, 0);
    chk(clk_hi > samples / 4 && clk_hi < 3 * samples / 4, "R3 out_clk duty", clk_hi, samples / 2);

    // jittered spacing, same mean
    wide_cnt = 0;
    for (int i = 0; i < 200; i++) begin
      case (i % 4)
        0: wr(5);
        1: wr(11);
        2: wr(7);
        default: wr(9);
      endcase
    end
    chk(wide_cnt == 0, "R5 wide during jitter", wide_cnt, 0);
    chk(ovf_cnt + unf_cnt == 0, "R5 events during jitter", ovf_cnt + unf_cnt, 0);

    // writes stop: drain to underflow
    wide_cnt = 0;
    for (int i = 0; i < 3000 && unf_cnt == 0; i++) @(negedge clk);
    chk(unf_cnt == 1, "R7 underflow event", unf_cnt, 1);
    chk(wide_at_evt > 0, "R4 wide before underflow", wide_at_evt, 1);
    for (int i = 0; i < 100; i++) wr(8);
    chk(wide_bw == 0, "R4 wide cleared after recentre", int'(wide_bw), 0);
    chk(unf_cnt == 1 && ovf_cnt == 0, "R7 no further events", unf_cnt + ovf_cnt, 1);

    // back-to-back writes: fill to overflow
    wide_cnt = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (ovf_cnt > 0) break;
      in_valid = 1'b1;
      in_data  = 2'((sym_k % 3) + 1);
      sym_k++;
      exp_q.push_back(in_data);
    end
    in_valid = 1'b0;
    chk(ovf_cnt == 1, "R6 overflow event", ovf_cnt, 1);
    chk(wide_at_evt > 0, "R4 wide before overflow", wide_at_evt, 1);

    // depth change in mid-stream
    wait_read_slot();
    depth_sel = 1'b1;
    dcur = 64;
    exp_q.delete();
    push_zeros(32);
    wide_cnt = 0;
    for (int i = 0; i < 150; i++) wr(8);
    chk(wide_cnt == 0, "R8 wide at depth 64", wide_cnt, 0);
    chk(ovf_cnt == 1 && unf_cnt == 1, "R8 no events at depth 64", ovf_cnt + unf_cnt, 2);

    // bypass path
    wait_read_slot();
    mon_on = 0;
    bypass = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      logic [1:0] s;
      s = 2'(i % 4);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = s;
      @(posedge clk); #1;
      chk(out_valid == 1 && out_data == s, "R9 bypass symbol", int'({out_valid, out_data}),
          int'({1'b1, s}));
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      chk(out_valid == 0 && ovf_evt == 0 && unf_evt == 0, "R9 bypass idle",
          int'({out_valid, ovf_evt, unf_evt}), 0);
    end
    done = 1;
    summary();
  end
endmodule